// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor with Return Stack

This block sits beside the instruction fetch unit. Every cycle the fetch PC is presented on the lookup side. The block answers in the same cycle with three things: whether that exact address is a known branch, the address to fetch next, and a taken hint. Known branches live in a direct-mapped table of full-address tags, targets and a single taken bit. When an entry is marked as a return, its target comes from a small circular stack of return addresses instead of from the stored target.

The resolution side is driven by the back end when a branch completes. It carries the branch address, the resolved target, the outcome and whether the instruction was a call or a return. The update rewrites the table slot that the branch address selects. A call pushes its fall-through address onto the stack, and a return pops it. All state changes take effect at the clock edge, so a lookup in the same cycle still sees the previous contents.

Top module: `btb_fetch_predictor`

## Requirements
- R1: The table slot is selected by PC bits [IDX_W+1:2]. Two addresses that differ only above bit IDX_W+1 share one slot, and the latest update to that slot wins.
- R2: A lookup hits only when the slot is valid and its stored tag equals the whole 32-bit lookup PC. On a miss, hit and taken are 0 and the next PC is lookup PC + 4.
- R3: On a hit to a non-return entry, taken equals the stored taken bit. The next PC is the stored target when taken is 1, and lookup PC + 4 when it is 0.
- R4: On a hit to an entry marked as a return, taken is 1 and the next PC is the current top of the return stack, which is the most recently pushed address not yet popped.
- R5: An update with up_valid_i=1 writes the tag, target, taken bit and return flag into the slot of up_pc_i. It marks the slot valid and replaces any previous occupant. The new contents are visible to lookups from the next cycle.
- R6: A lookup in the same cycle as an update to the same slot returns the slot's contents from before that update.
- R7: An update that is a call and not a return pushes up_pc_i + 4. An update that is a return and not a call pops the stack. The stack holds 8 entries and is circular: a ninth push overwrites the oldest entry, and popping past the bottom wraps around.
- R8: An update flagged as both call and return replaces the top of the stack with up_pc_i + 4 without moving the pointer.
- R9: After reset, every slot is invalid and every stack entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_pc_i | input | 32 | Fetch PC to look up |
| lk_hit_o | output | 1 | Lookup PC is a known branch |
| lk_next_pc_o | output | 32 | Predicted next fetch address |
| lk_taken_o | output | 1 | Taken hint |
| up_valid_i | input | 1 | Resolution update present |
| up_pc_i | input | 32 | Address of the resolved branch |
| up_target_i | input | 32 | Resolved target |
| up_taken_i | input | 1 | Resolved outcome |
| up_call_i | input | 1 | Resolved branch is a call |
| up_ret_i | input | 1 | Resolved branch is a return |

## Verification
A corrupted tag, target or taken bit appears on the lookup outputs the first cycle that slot's address is fetched again. A wrong index mapping shows up as hits on addresses that were never trained, or as lost training when aliases are interleaved. A stack pointer that is off by one, or that wraps wrongly, stays hidden until a return entry is looked up. At that point the next PC equals a neighbouring stack entry, so the bench runs deep call chains beyond eight and pop runs that cross the bottom. Same-cycle update and lookup pairs expose any bypass that was not intended.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned PC_W = 32;

  typedef struct packed {
    logic            valid;
    logic            is_ret;
    logic            taken;
    logic [PC_W-1:0] tag;
    logic [PC_W-1:0] target;
  } btb_entry_t;

  typedef enum logic [1:0] {
    RAS_HOLD = 2'd0,
    RAS_PUSH = 2'd1,
    RAS_POP  = 2'd2,
    RAS_SWAP = 2'd3
  } ras_op_e;
endpackage

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output btb_entry_t       rd_entry_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  btb_entry_t       wr_entry_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  btb_entry_t slot_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
        slot_q[g] <= wr_entry_i;
      end
    end
  end

  // read sees pre-edge contents
  assign rd_entry_o = slot_q[rd_idx_i];
endmodule

// File: rtl/btb_ras.sv
module btb_ras
  import btb_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ras_op_e         op_i,
  input  logic [PC_W-1:0] push_val_i,
  output logic [PC_W-1:0] top_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] top_idx;
  logic [PTR_W-1:0] wr_idx;
  logic             wr_en;
  logic [PC_W-1:0]  stk_q [DEPTH];

  // DEPTH is a power of two: pointer arithmetic wraps naturally
  assign top_idx = sp_q - PTR_W'(1);
  assign wr_en   = (op_i == RAS_PUSH) || (op_i == RAS_SWAP);
  assign wr_idx  = (op_i == RAS_PUSH) ? sp_q : top_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else begin
      unique case (op_i)
        RAS_PUSH: sp_q <= sp_q + PTR_W'(1);
        RAS_POP:  sp_q <= top_idx;
        default:  sp_q <= sp_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stk_q[g] <= '0;
      end else if (wr_en && (wr_idx == PTR_W'(g))) begin
        stk_q[g] <= push_val_i;
      end
    end
  end

  assign top_o = stk_q[top_idx];
endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor
  import btb_pkg::*;
#(
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned RAS_DEPTH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_hit_o,
  output logic [PC_W-1:0] lk_next_pc_o,
  output logic            lk_taken_o,
  input  logic            up_valid_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic [PC_W-1:0] up_target_i,
  input  logic            up_taken_i,
  input  logic            up_call_i,
  input  logic            up_ret_i
);
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

  btb_entry_t      rd_entry;
  btb_entry_t      wr_entry;
  ras_op_e         ras_op;
  logic [PC_W-1:0] ras_top;
  logic [PC_W-1:0] lk_fall;
  logic [PC_W-1:0] up_fall;

  assign lk_fall = lk_pc_i + PC_W'(4);
  assign up_fall = up_pc_i + PC_W'(4);

  assign wr_entry = '{valid:  1'b1,
                      is_ret: up_ret_i,
                      taken:  up_taken_i,
                      tag:    up_pc_i,
                      target: up_target_i};

  btb_table #(.IDX_W(IDX_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lk_pc_i[IDX_HI:IDX_LO]),
    .rd_entry_o(rd_entry),
    .wr_en_i   (up_valid_i),
    .wr_idx_i  (up_pc_i[IDX_HI:IDX_LO]),
    .wr_entry_i(wr_entry)
  );

  always_comb begin
    ras_op = RAS_HOLD;
    if (up_valid_i) begin
      unique case ({up_call_i, up_ret_i})
        2'b10:   ras_op = RAS_PUSH;
        2'b01:   ras_op = RAS_POP;
        2'b11:   ras_op = RAS_SWAP;
        default: ras_op = RAS_HOLD;
      endcase
    end
  end

  btb_ras #(.DEPTH(RAS_DEPTH)) u_ras (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (ras_op),
    .push_val_i(up_fall),
    .top_o     (ras_top)
  );

  always_comb begin
    lk_hit_o     = rd_entry.valid && (rd_entry.tag == lk_pc_i);
    lk_taken_o   = 1'b0;
    lk_next_pc_o = lk_fall;
    if (lk_hit_o) begin
      if (rd_entry.is_ret) begin
        lk_taken_o   = 1'b1;
        lk_next_pc_o = ras_top;
      end else if (rd_entry.taken) begin
        lk_taken_o   = 1'b1;
        lk_next_pc_o = rd_entry.target;
      end
    end
  end
endmodule

// File: rtl/btb_fetch_predictor_chk.sv
module btb_fetch_predictor_chk
  import btb_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_hit_o,
  input logic [PC_W-1:0] lk_next_pc_o,
  input logic            lk_taken_o,
  input logic            up_valid_i,
  input logic [PC_W-1:0] up_pc_i,
  input logic            up_call_i,
  input logic            up_ret_i,
  input logic [PC_W-1:0] ras_top
);
  // R2: a miss falls through
  a_r2_miss_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> (!lk_taken_o && lk_next_pc_o == lk_pc_i + PC_W'(4)));

  // R3: not-taken hit falls through
  a_r3_not_taken_fallthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && !lk_taken_o) |-> (lk_next_pc_o == lk_pc_i + PC_W'(4)));

  // R5: a trained address hits on the following cycle
  a_r5_update_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_valid_i |=> (lk_pc_i != $past(up_pc_i)) || lk_hit_o);

  // R4: a trained return predicts from the stack top
  a_r4_return_from_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_ret_i && !up_call_i) |=>
      (lk_pc_i != $past(up_pc_i)) || (lk_taken_o && lk_next_pc_o == ras_top));

  // R7, R8: a call leaves its fall-through on top
  a_r7_call_on_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_call_i) |=> (ras_top == $past(up_pc_i) + PC_W'(4)));
endmodule

bind btb_fetch_predictor btb_fetch_predictor_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lk_pc_i     (lk_pc_i),
  .lk_hit_o    (lk_hit_o),
  .lk_next_pc_o(lk_next_pc_o),
  .lk_taken_o  (lk_taken_o),
  .up_valid_i  (up_valid_i),
  .up_pc_i     (up_pc_i),
  .up_call_i   (up_call_i),
  .up_ret_i    (up_ret_i),
  .ras_top     (ras_top)
);

// File: tb/btb_fetch_predictor_test.sv
module btb_fetch_predictor_test;
  localparam int CLK_PERIOD = 10;
  localparam int SLOTS      = 16;
  localparam int STK        = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lk_pc_i = '0;
  logic        lk_hit_o;
  logic [31:0] lk_next_pc_o;
  logic        lk_taken_o;
  logic        up_valid_i = 1'b0;
  logic [31:0] up_pc_i = '0;
  logic [31:0] up_target_i = '0;
  logic        up_taken_i = 1'b0;
  logic        up_call_i = 1'b0;
  logic        up_ret_i = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural model: training keyed by slot, stack as a ring of addresses
  bit          m_valid [SLOTS];
  bit          m_ret   [SLOTS];
  bit          m_tk    [SLOTS];
  logic [31:0] m_tag   [SLOTS];
  logic [31:0] m_tgt   [SLOTS];
  logic [31:0] m_stk   [STK];
  int          m_sp;

  btb_fetch_predictor uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .lk_pc_i(lk_pc_i),
    .lk_hit_o(lk_hit_o), .lk_next_pc_o(lk_next_pc_o), .lk_taken_o(lk_taken_o),
    .up_valid_i(up_valid_i), .up_pc_i(up_pc_i), .up_target_i(up_target_i),
    .up_taken_i(up_taken_i), .up_call_i(up_call_i), .up_ret_i(up_ret_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic int slot_of(logic [31:0] pc);
    return int'(pc[5:2]);  // R1
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < SLOTS; i++) begin
      m_valid[i] = 0; m_ret[i] = 0; m_tk[i] = 0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    for (int i = 0; i < STK; i++) m_stk[i] = '0;
    m_sp = 0;
  endfunction

  task automatic compare(string phase);
    int s = slot_of(lk_pc_i);
    bit e_hit, e_tk;
    logic [31:0] e_nx;
    string req;
    e_hit = m_valid[s] && (m_tag[s] == lk_pc_i);
    e_tk = 0; e_nx = lk_pc_i + 32'd4; req = "R2";
    if (e_hit && m_ret[s]) begin
      e_tk = 1; e_nx = m_stk[(m_sp + STK - 1) % STK]; req = "R4";
    end else if (e_hit) begin
      req = "R3";
      if (m_tk[s]) begin e_tk = 1; e_nx = m_tgt[s]; end
    end
    n_cmp++;
    if (lk_hit_o !== e_hit || lk_taken_o !== e_tk || lk_next_pc_o !== e_nx) begin
      n_bad++;
      $display("FAIL %s/%s pc=%h actual hit=%b tk=%b nx=%h expected hit=%b tk=%b nx=%h",
               phase, req, lk_pc_i, lk_hit_o, lk_taken_o, lk_next_pc_o, e_hit, e_tk, e_nx);
    end
  endtask

  function automatic void model_edge();
    if (!up_valid_i) return;
    begin
      int s = slot_of(up_pc_i);
      m_valid[s] = 1; m_ret[s] = up_ret_i; m_tk[s] = up_taken_i;
      m_tag[s] = up_pc_i; m_tgt[s] = up_target_i;
    end
    if (up_call_i && up_ret_i) m_stk[(m_sp + STK - 1) % STK] = up_pc_i + 32'd4;
    else if (up_call_i) begin m_stk[m_sp] = up_pc_i + 32'd4; m_sp = (m_sp + 1) % STK; end
    else if (up_ret_i) m_sp = (m_sp + STK - 1) % STK;
  endfunction

  task automatic step(string phase, logic [31:0] lpc, bit uv, logic [31:0] upc,
                      logic [31:0] utg, bit utk, bit ucall, bit uret);
    @(negedge clk_i);
    lk_pc_i = lpc; up_valid_i = uv; up_pc_i = upc; up_target_i = utg;
    up_taken_i = utk; up_call_i = ucall; up_ret_i = uret;
    #1;
    compare(phase);
    @(posedge clk_i);
    model_edge();
  endtask

  task automatic look(string phase, logic [31:0] lpc);
    step(phase, lpc, 0, '0, '0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R9: nothing trained after reset
    look("R9", 32'h0000_1000);
    look("R9", 32'h0000_003c);
    // R5, R3: train taken and not-taken branches, then look them up
    step("R5", 32'h0, 1, 32'h0000_1004, 32'h0000_2000, 1, 0, 0);
    look("R3", 32'h0000_1004);
    step("R5", 32'h0, 1, 32'h0000_1008, 32'h0000_3000, 0, 0, 0);
    look("R3", 32'h0000_1008);
    // R2: same slot, different upper bits misses
    look("R2", 32'h0000_1044);
    look("R2", 32'h8000_1004);
    // R1: alias replaces the slot
    step("R1", 32'h0, 1, 32'h0000_1044, 32'h0000_4000, 1, 0, 0);
    look("R1", 32'h0000_1004);
    look("R1", 32'h0000_1044);
    // R6: same-cycle update and lookup sees old contents
    step("R6", 32'h0000_1010, 1, 32'h0000_1010, 32'h0000_5000, 1, 0, 0);
    look("R6", 32'h0000_1010);
    step("R6", 32'h0000_1010, 1, 32'h0000_1010, 32'h0000_6000, 0, 0, 0);
    look("R6", 32'h0000_1010);
    // R7: calls then a trained return
    step("R7", 32'h0, 1, 32'h0000_0100, 32'h0000_9000, 1, 1, 0);
    step("R7", 32'h0, 1, 32'h0000_0200, 32'h0000_9100, 1, 1, 0);
    step("R4", 32'h0, 1, 32'h0000_0a0c, 32'h0, 1, 0, 1);
    look("R4", 32'h0000_0a0c);
    step("R7", 32'h0, 1, 32'h0000_0a0c, 32'h0, 1, 0, 1);
    look("R4", 32'h0000_0a0c);
    // R7: overflow past 8 pushes, then pop beyond the bottom
    for (int k = 0; k < 11; k++)
      step("R7", 32'h0000_0a0c, 1, 32'h0000_0400 + 32'(k * 64), 32'h0, 1, 1, 0);
    for (int k = 0; k < 12; k++)
      step("R7", 32'h0000_0a0c, 1, 32'h0000_0a0c, 32'h0, 1, 0, 1);
    look("R7", 32'h0000_0a0c);
    // R8: call and return together swaps the top
    step("R8", 32'h0000_0a0c, 1, 32'h0000_0700, 32'h0, 1, 1, 1);
    look("R8", 32'h0000_0a0c);
    // mixed random traffic with heavy aliasing
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      int r;
      a = 32'h0000_1000 | (32'($urandom_range(0, 3)) << 6) | (32'($urandom_range(0, 15)) << 2);
      b = 32'h0000_1000 | (32'($urandom_range(0, 3)) << 6) | (32'($urandom_range(0, 15)) << 2);
      r = $urandom_range(0, 9);
      step("RND", a, r < 6, b, 32'h0002_0000 + 32'($urandom_range(0, 4095)) * 4,
           $urandom_range(0, 1) == 1, r == 1 || r == 3, r == 2 || r == 3);
    end
    // R9: reset mid-run clears everything
    @(negedge clk_i);
    up_valid_i = 0;
    rst_ni = 0;
    model_reset();
    #(CLK_PERIOD * 2);
    @(negedge clk_i);
    rst_ni = 1;
    look("R9", 32'h0000_1004);
    look("R9", 32'h0000_0a0c);
    finish_run();
  end
endmodule